// File: doc/BRIEF.md
# CAN Receive Message Ring Buffer

This block holds accepted CAN frames in a byte-wide circular store so that software or a downstream engine can read them one message at a time. Each frame arrives as a parallel bundle (identifier, extended and remote-request flags, data length code and eight data bytes). It is packed into a variable-length record: one header byte, then two or four identifier bytes, then the data bytes the frame carries. Records sit back to back with no padding, and the storage pointer wraps at the end of the buffer.

Writing a record takes one clock per byte. A frame that would not fit in the remaining space is dropped whole and a sticky overrun flag is raised. A fixed-size read window presents the bytes of the oldest record, counted from its header. A release command discards that record by advancing the head pointer by a length that is recomputed from the stored header. Byte and message counters are visible at the ports, together with a ready flag, a receive interrupt and a "writing" indication.

Top module: `can_rx_ring`

## Requirements
- R1: Every record starts with a header byte laid out as {extended flag in bit 7, remote flag in bit 6, zeros in bits 5:4, DLC in bits 3:0}. An extended record then holds four identifier bytes: id[28:21], id[20:13], id[12:5], and {id[4:0], 3'b000}. Data bytes follow from record offset 5, with data byte j taken from frmData[8j+7:8j].
- R2: A standard record holds two identifier bytes after the header: id[10:3], then {id[2:0], 5'b00000}. Data bytes follow from record offset 3.
- R3: A record is (extended ? 5 : 3) bytes long, plus min(DLC, 8) data bytes when the remote flag is clear and no data bytes when it is set. When the write finishes, byteCount grows by that length and msgCount grows by one. byteCount never exceeds BUF_BYTES (64).
- R4: If byteCount plus the new record length would exceed BUF_BYTES, the frame is dropped whole and byteCount, msgCount and the stored bytes do not change. overrun and ovrIrq are then set on the next clock and stay set until an ovrClr pulse clears both.
- R5: A release while msgCount is non-zero advances the head by the length of the head record, recomputed from its header byte by the R3 rule and taken modulo BUF_BYTES. It lowers byteCount by that length and msgCount by one.
- R6: A release that empties the buffer clears rxReady and rxIrq. A release while msgCount is zero changes nothing.
- R7: For winOffset k below 13, winData shows the byte at (head + k) mod BUF_BYTES. For offsets 13 to 15 it shows 0.
- R8: receiving is high for exactly the record-length clocks that follow the clock on which a store was accepted. It does not rise for a dropped frame.
- R9: A storeReq that arrives while a record is still being written is ignored.
- R10: After reset, the counters, all flags, receiving and every stored byte are zero.
- R11: When a record write completes, rxReady and rxIrq are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| storeReq | input | 1 | One-clock request to store the presented frame |
| frmExt | input | 1 | Frame uses the 29-bit identifier |
| frmRtr | input | 1 | Frame is a remote request |
| frmId | input | 29 | Identifier (standard frames use bits 10:0) |
| frmDlc | input | 4 | Data length code |
| frmData | input | 64 | Data bytes, byte j in bits 8j+7:8j |
| relReq | input | 1 | One-clock request to release the head record |
| ovrClr | input | 1 | Clears overrun and ovrIrq |
| winOffset | input | 4 | Read-window offset from the head record |
| winData | output | 8 | Byte at the window offset |
| receiving | output | 1 | A record is being written |
| rxReady | output | 1 | At least one record is stored |
| rxIrq | output | 1 | Receive interrupt |
| overrun | output | 1 | Sticky overrun status |
| ovrIrq | output | 1 | Overrun interrupt |
| byteCount | output | 7 | Bytes held |
| msgCount | output | 7 | Records held |

## Verification
A head pointer that drifts away from a record boundary shows up at once in the read window: offset 0 stops showing a well-formed header, and the next release then moves by the wrong length, so byteCount disagrees with the model after one more release. A wrong length rule for remote or long-DLC frames appears in byteCount as soon as the write completes, which is length clocks after acceptance. The sweep covers every combination of format, remote flag and DLC. A fill sequence then wraps the pointers, lands exactly on the full mark and forces an overrun, so a faulty fit test shows in the counters on the clock after the offending request.

// File: rtl/can_rx_ring_pkg.sv
package can_rx_ring_pkg;

  typedef struct packed {
    logic latchFrame;   // capture the incoming frame for serialisation
    logic writeByte;    // write one serialised byte this clock
  } ringStrobes_t;

  // Record length derived from header fields; long DLC values saturate at 8.
  function automatic logic [3:0] msgLen(input logic ext, input logic rtr,
                                        input logic [3:0] dlc);
    logic [3:0] dataBytes;
    dataBytes = rtr ? 4'd0 : ((dlc > 4'd8) ? 4'd8 : dlc);
    return (ext ? 4'd5 : 4'd3) + dataBytes;
  endfunction

  // Wrap-around addition for a ring of the given size.
  function automatic int unsigned ringAdd(input int unsigned base,
                                          input int unsigned step,
                                          input int unsigned size);
    int unsigned s;
    s = base + step;
    return (s >= size) ? s - size : s;
  endfunction

  // Byte idx of the serialised record.
  function automatic logic [7:0] recordByte(input logic ext, input logic rtr,
                                            input logic [3:0] dlc,
                                            input logic [28:0] id,
                                            input logic [63:0] data,
                                            input logic [3:0] idx);
    logic [7:0] b;
    logic [2:0] dIdx;
    b = 8'h00;
    dIdx = 3'd0;
    if (idx == 4'd0) begin
      b = {ext, rtr, 2'b00, dlc};
    end else if (ext) begin
      case (idx)
        4'd1: b = id[28:21];
        4'd2: b = id[20:13];
        4'd3: b = id[12:5];
        4'd4: b = {id[4:0], 3'b000};
        default: begin
          dIdx = 3'(idx - 4'd5);
          b = data[{dIdx, 3'b000} +: 8];
        end
      endcase
    end else begin
      case (idx)
        4'd1: b = id[10:3];
        4'd2: b = {id[2:0], 5'b00000};
        default: begin
          dIdx = 3'(idx - 4'd3);
          b = data[{dIdx, 3'b000} +: 8];
        end
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/can_rx_ring_ctrl.sv
module can_rx_ring_ctrl
  import can_rx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int PTR_W = $clog2(BUF_BYTES),
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             storeReq,
  input  logic             frmExt,
  input  logic             frmRtr,
  input  logic [3:0]       frmDlc,
  input  logic             relReq,
  input  logic             ovrClr,
  input  logic             headExt,
  input  logic             headRtr,
  input  logic [3:0]       headDlc,
  output ringStrobes_t     strobes,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] wrAddr,
  output logic [3:0]       wrIdx,
  output logic             receiving,
  output logic             rxReady,
  output logic             rxIrq,
  output logic             overrun,
  output logic             ovrIrq,
  output logic [CNT_W-1:0] byteCount,
  output logic [CNT_W-1:0] msgCount
);

  logic             busy;
  logic [3:0]       curLen;
  logic [PTR_W-1:0] tailPtr;
  logic [3:0]       newLen;
  logic [3:0]       relLen;
  logic             fits;
  logic             acceptStore;
  logic             dropStore;
  logic             relDo;
  logic             lastByte;
  logic [CNT_W-1:0] byteNext;
  logic [CNT_W-1:0] msgNext;

  always_comb begin
    newLen      = msgLen(frmExt, frmRtr, frmDlc);
    relLen      = msgLen(headExt, headRtr, headDlc);
    fits        = ({1'b0, byteCount} + (CNT_W+1)'(newLen)) <= (CNT_W+1)'(BUF_BYTES);
    acceptStore = storeReq && !busy && fits;
    dropStore   = storeReq && !busy && !fits;
    relDo       = relReq && (msgCount != '0);
    lastByte    = busy && (wrIdx == (curLen - 4'd1));
    byteNext    = byteCount + (lastByte ? CNT_W'(curLen) : '0)
                            - (relDo ? CNT_W'(relLen) : '0);
    msgNext     = msgCount + (lastByte ? CNT_W'(1) : '0)
                           - (relDo ? CNT_W'(1) : '0);
    wrAddr      = PTR_W'(ringAdd(32'(tailPtr), 32'(wrIdx), BUF_BYTES));
    strobes.latchFrame = acceptStore;
    strobes.writeByte  = busy;
    receiving   = busy;
  end

  // Record writer: one byte per clock from acceptance until the last byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      wrIdx   <= '0;
      curLen  <= '0;
      tailPtr <= '0;
    end else if (acceptStore) begin
      busy   <= 1'b1;
      wrIdx  <= '0;
      curLen <= newLen;
    end else if (busy) begin
      if (lastByte) begin
        busy    <= 1'b0;
        tailPtr <= PTR_W'(ringAdd(32'(tailPtr), 32'(curLen), BUF_BYTES));
      end else begin
        wrIdx <= wrIdx + 4'd1;
      end
    end
  end

  // Head pointer, occupancy and flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      byteCount <= '0;
      msgCount  <= '0;
      rxReady   <= 1'b0;
      rxIrq     <= 1'b0;
      overrun   <= 1'b0;
      ovrIrq    <= 1'b0;
    end else begin
      if (relDo)
        headPtr <= PTR_W'(ringAdd(32'(headPtr), 32'(relLen), BUF_BYTES));
      byteCount <= byteNext;
      msgCount  <= msgNext;
      if (lastByte) begin
        rxReady <= 1'b1;
        rxIrq   <= 1'b1;
      end else if (relDo && (msgCount == CNT_W'(1))) begin
        rxReady <= 1'b0;
        rxIrq   <= 1'b0;
      end
      if (dropStore) begin
        overrun <= 1'b1;
        ovrIrq  <= 1'b1;
      end else if (ovrClr) begin
        overrun <= 1'b0;
        ovrIrq  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/can_rx_ring_dp.sv
module can_rx_ring_dp
  import can_rx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int WIN_BYTES = 13,
  localparam int PTR_W = $clog2(BUF_BYTES),
  localparam int OFF_W = $clog2(WIN_BYTES + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobes_t     strobes,
  input  logic             frmExt,
  input  logic             frmRtr,
  input  logic [28:0]      frmId,
  input  logic [3:0]       frmDlc,
  input  logic [63:0]      frmData,
  input  logic [PTR_W-1:0] wrAddr,
  input  logic [3:0]       wrIdx,
  input  logic [PTR_W-1:0] headPtr,
  input  logic [OFF_W-1:0] winOffset,
  output logic             headExt,
  output logic             headRtr,
  output logic [3:0]       headDlc,
  output logic [7:0]       winData
);

  logic [7:0]  mem [BUF_BYTES];
  logic        latExt;
  logic        latRtr;
  logic [3:0]  latDlc;
  logic [28:0] latId;
  logic [63:0] latData;
  logic [7:0]  headInfo;
  logic [PTR_W-1:0] rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latExt  <= 1'b0;
      latRtr  <= 1'b0;
      latDlc  <= '0;
      latId   <= '0;
      latData <= '0;
    end else if (strobes.latchFrame) begin
      latExt  <= frmExt;
      latRtr  <= frmRtr;
      latDlc  <= frmDlc;
      latId   <= frmId;
      latData <= frmData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
    end else if (strobes.writeByte) begin
      mem[wrAddr] <= recordByte(latExt, latRtr, latDlc, latId, latData, wrIdx);
    end
  end

  always_comb begin
    headInfo = mem[headPtr];
    headExt  = headInfo[7];
    headRtr  = headInfo[6];
    headDlc  = headInfo[3:0];
    rdAddr   = PTR_W'(ringAdd(32'(headPtr), 32'(winOffset), BUF_BYTES));
    winData  = (32'(winOffset) < WIN_BYTES) ? mem[rdAddr] : 8'h00;
  end

endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
  import can_rx_ring_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int WIN_BYTES = 13,
  localparam int PTR_W = $clog2(BUF_BYTES),
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int OFF_W = $clog2(WIN_BYTES + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             storeReq,
  input  logic             frmExt,
  input  logic             frmRtr,
  input  logic [28:0]      frmId,
  input  logic [3:0]       frmDlc,
  input  logic [63:0]      frmData,
  input  logic             relReq,
  input  logic             ovrClr,
  input  logic [OFF_W-1:0] winOffset,
  output logic [7:0]       winData,
  output logic             receiving,
  output logic             rxReady,
  output logic             rxIrq,
  output logic             overrun,
  output logic             ovrIrq,
  output logic [CNT_W-1:0] byteCount,
  output logic [CNT_W-1:0] msgCount
);

  ringStrobes_t     strobes;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] wrAddr;
  logic [3:0]       wrIdx;
  logic             headExt;
  logic             headRtr;
  logic [3:0]       headDlc;

  can_rx_ring_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .storeReq(storeReq), .frmExt(frmExt),
    .frmRtr(frmRtr), .frmDlc(frmDlc), .relReq(relReq), .ovrClr(ovrClr),
    .headExt(headExt), .headRtr(headRtr), .headDlc(headDlc),
    .strobes(strobes), .headPtr(headPtr), .wrAddr(wrAddr), .wrIdx(wrIdx),
    .receiving(receiving), .rxReady(rxReady), .rxIrq(rxIrq),
    .overrun(overrun), .ovrIrq(ovrIrq), .byteCount(byteCount),
    .msgCount(msgCount)
  );

  can_rx_ring_dp #(.BUF_BYTES(BUF_BYTES), .WIN_BYTES(WIN_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .frmExt(frmExt),
    .frmRtr(frmRtr), .frmId(frmId), .frmDlc(frmDlc), .frmData(frmData),
    .wrAddr(wrAddr), .wrIdx(wrIdx), .headPtr(headPtr),
    .winOffset(winOffset), .headExt(headExt), .headRtr(headRtr),
    .headDlc(headDlc), .winData(winData)
  );

endmodule

// File: rtl/can_rx_ring_chk.sv
module can_rx_ring_chk #(
  parameter int BUF_BYTES = 64,
  parameter int WIN_BYTES = 13,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int OFF_W = $clog2(WIN_BYTES + 3)
) (
  input logic             clk,
  input logic             rstN,
  input logic             relReq,
  input logic             ovrClr,
  input logic [OFF_W-1:0] winOffset,
  input logic [7:0]       winData,
  input logic             receiving,
  input logic             rxReady,
  input logic             overrun,
  input logic [CNT_W-1:0] byteCount,
  input logic [CNT_W-1:0] msgCount
);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_W'(BUF_BYTES));

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(receiving) && !$past(relReq)) |-> msgCount == CNT_W'($past(msgCount) + 1'b1));

  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> !receiving);

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClr) |=> overrun);

  assert_empty_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (relReq && msgCount == '0 && !receiving) |=> (msgCount == '0 && $stable(byteCount)));

  assert_empty_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteCount == '0) == (msgCount == '0));

  assert_ready_track_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxReady == (msgCount != '0));

  assert_window_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (32'(winOffset) >= WIN_BYTES) |-> winData == 8'h00);

endmodule

bind can_rx_ring can_rx_ring_chk #(.BUF_BYTES(BUF_BYTES), .WIN_BYTES(WIN_BYTES)) u_chk (.*);

// File: tb/can_rx_ring_tb.sv
`timescale 1ns/1ps
module can_rx_ring_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        storeReq = 1'b0;
  logic        frmExt = 1'b0;
  logic        frmRtr = 1'b0;
  logic [28:0] frmId = '0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic        relReq = 1'b0;
  logic        ovrClr = 1'b0;
  logic [3:0]  winOffset = '0;
  logic [7:0]  winData;
  logic        receiving, rxReady, rxIrq, overrun, ovrIrq;
  logic [6:0]  byteCount, msgCount;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mdl [64];
  int mHead = 0, mTail = 0, mBytes = 0, mMsgs = 0;

  always #2 clk = ~clk;

  can_rx_ring u_dut (.*);

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOf(input bit ext, input bit rtr, input int dlc);
    return (ext ? 5 : 3) + (rtr ? 0 : (dlc > 8 ? 8 : dlc));
  endfunction

  function automatic int expByte(input bit ext, input bit rtr, input int dlc,
                                 input logic [28:0] id, input logic [63:0] data, input int k);
    if (k == 0) return (ext ? 128 : 0) + (rtr ? 64 : 0) + dlc;
    if (ext) begin
      if (k == 1) return int'((id >> 21) & 29'hFF);
      if (k == 2) return int'((id >> 13) & 29'hFF);
      if (k == 3) return int'((id >> 5) & 29'hFF);
      if (k == 4) return int'(id & 29'h1F) * 8;
      return int'((data >> (8 * (k - 5))) & 64'hFF);
    end
    if (k == 1) return int'((id >> 3) & 29'hFF);
    if (k == 2) return int'(id & 29'h7) * 32;
    return int'((data >> (8 * (k - 3))) & 64'hFF);
  endfunction

  task automatic modelPush(input bit ext, input bit rtr, input int dlc,
                           input logic [28:0] id, input logic [63:0] data);
    int len;
    len = lenOf(ext, rtr, dlc);
    for (int k = 0; k < len; k++) mdl[(mTail + k) % 64] = expByte(ext, rtr, dlc, id, data, k);
    mTail = (mTail + len) % 64;
    mBytes += len;
    mMsgs++;
  endtask

  task automatic checkWindow(input string req);
    for (int k = 0; k < 16; k++) begin
      winOffset = 4'(k);
      #0.25;
      chkEq(req, int'(winData), (k < 13) ? mdl[(mHead + k) % 64] : 0);
    end
    winOffset = 4'd0;
  endtask

  task automatic checkCounts(input string req);
    chkEq(req, int'(byteCount), mBytes);
    chkEq(req, int'(msgCount), mMsgs);
    chkEq(req, int'(rxReady), mMsgs != 0);
    chkEq(req, int'(rxIrq), mMsgs != 0);
  endtask

  task automatic doStore(input bit ext, input bit rtr, input int dlc,
                         input logic [28:0] id, input logic [63:0] data);
    int len;
    bit fits;
    len = lenOf(ext, rtr, dlc);
    fits = (mBytes + len) <= 64;
    @(negedge clk);
    storeReq = 1'b1; frmExt = ext; frmRtr = rtr; frmDlc = 4'(dlc);
    frmId = id; frmData = data;
    @(negedge clk);
    storeReq = 1'b0;
    if (fits) begin
      chkEq("R8 receiving after accept", int'(receiving), 1);
      repeat (len - 1) @(negedge clk);
      chkEq("R8 receiving last byte", int'(receiving), 1);
      @(negedge clk);
      chkEq("R8 receiving done", int'(receiving), 0);
      modelPush(ext, rtr, dlc, id, data);
      checkCounts("R3 R11 store counts");
    end else begin
      chkEq("R4 overrun set", int'(overrun), 1);
      chkEq("R4 ovrIrq set", int'(ovrIrq), 1);
      chkEq("R8 no receiving on drop", int'(receiving), 0);
      checkCounts("R4 counts kept");
    end
    checkWindow("R1 R2 R7 window");
  endtask

  task automatic doRelease();
    int info, len;
    @(negedge clk);
    relReq = 1'b1;
    @(negedge clk);
    relReq = 1'b0;
    if (mMsgs > 0) begin
      info = mdl[mHead];
      len = lenOf(info[7], info[6], info & 15);
      mHead = (mHead + len) % 64;
      mBytes -= len;
      mMsgs--;
    end
    checkCounts("R5 R6 release counts");
    checkWindow("R5 R7 head window");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R10 receiving", int'(receiving), 0);
    chkEq("R10 overrun", int'(overrun), 0);
    chkEq("R10 ovrIrq", int'(ovrIrq), 0);
    checkCounts("R10 reset counts");
    checkWindow("R10 reset bytes");

    // Sweep every format, remote flag and DLC value.
    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          logic [28:0] id;
          logic [63:0] data;
          id = e ? 29'((32'h1ABCDEF3 ^ (d * 32'h01234567)) & 32'h1FFFFFFF)
                 : 29'((11'h5A5 ^ (d * 37)) & 11'h7FF);
          data = 64'h0123456789ABCDEF ^ (64'(d) * 64'h1111111111111111) ^ 64'(r * 255);
          doStore(e[0], r[0], d, id, data);
          doRelease();
        end

    // Fill to exactly full across the wrap point, then overrun.
    for (int i = 0; i < 4; i++) doStore(1'b1, 1'b0, 8, 29'(32'h10203040 + i), 64'hFEDCBA9876543210 + 64'(i));
    doStore(1'b1, 1'b0, 7, 29'h0ABCDE12, 64'h1122334455667788);
    chkEq("R3 exact full", int'(byteCount), 64);
    chkEq("R4 no overrun at full", int'(overrun), 0);
    doStore(1'b0, 1'b1, 2, 29'h123, 64'h0);
    doStore(1'b0, 1'b0, 0, 29'h7FF, 64'h0);
    @(negedge clk);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;
    chkEq("R4 overrun cleared", int'(overrun), 0);
    chkEq("R4 ovrIrq cleared", int'(ovrIrq), 0);
    for (int i = 0; i < 5; i++) doRelease();
    chkEq("R6 empty ready", int'(rxReady), 0);

    // Release with nothing stored.
    doRelease();
    chkEq("R6 empty release bytes", int'(byteCount), 0);

    // A second request during a write is ignored.
    @(negedge clk);
    storeReq = 1'b1; frmExt = 1'b0; frmRtr = 1'b0; frmDlc = 4'd8;
    frmId = 29'h2AA; frmData = 64'hA5A5A5A55A5A5A5A;
    @(negedge clk);
    frmExt = 1'b1; frmDlc = 4'd3; frmId = 29'h1F00FF00; frmData = 64'hFFFFFFFFFFFFFFFF;
    @(negedge clk);
    storeReq = 1'b0;
    repeat (12) @(negedge clk);
    modelPush(1'b0, 1'b0, 8, 29'h2AA, 64'hA5A5A5A55A5A5A5A);
    chkEq("R9 busy request ignored", int'(msgCount), 1);
    checkCounts("R9 counts");
    checkWindow("R9 window keeps first");
    doRelease();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule